// File: doc/BRIEF.md
# Attribute Bitmap Video Generator

This block turns a monochrome bitmap of 256 by 192 pixels plus a 32 by 24 grid of colour attributes into a raster signal. It outputs separate green, red and blue bits, a brightness bit, active-high horizontal and vertical sync, and a one-cycle frame interrupt. Each 8 by 8 pixel cell takes one attribute byte. Bits 2:0 of that byte give the ink colour, bits 5:3 give the paper colour, bit 6 sets bright and bit 7 sets flash. Every 3-bit colour is ordered green, red, blue from the most significant bit down. A set bitmap bit shows ink and a clear bit shows paper. A solid border in a 3-bit colour fills the active area around the bitmap.

For each cell the block reads display memory twice: the bitmap byte first, then the attribute byte. Each read comes one cell ahead of the pixels it feeds, and every read falls on an even cycle of the cell. This leaves every odd cycle, and most even ones, free for another master. Memory data is taken in at the end of the cycle in which the address is presented. A frame counter sets a flash phase. While the phase is active, cells with the flash bit show ink and paper swapped. Margins, porches, sync widths and the flash period are parameters.

Positions below are given in fetch coordinates (h, v). These are the counters that start at h=0, v=0 in the first cycle after reset is released, where h counts 0..H_TOTAL-1 and v counts 0..V_TOTAL-1. Video for position (h, v) appears on the outputs 9 cycles after that position's cycle.

Top module: `vidgen`

## Requirements
- R1: In a position with h<256, v<192 and h mod 8 = 0, memRd is high and memAddr = {1'b0, v[7:6], v[2:0], v[5:3], h[7:3]}.
- R2: In a position with h<256, v<192 and h mod 8 = 2, memRd is high and memAddr = 0x1800 + (v/8)*32 + h/8.
- R3: memRd is low in every other cycle, so reads occupy only even cycles and never two cycles in a row.
- R4: For a bitmap position, the colour outputs show ink when bit (7 - h mod 8) of the bitmap byte is set and paper when it is clear, 9 cycles after the position.
- R5: vidBright is 1 only for a bitmap pixel whose attribute has bit 6 set and whose shown colour is not black (000).
- R6: In frames where the flash phase is active (frame index bit FLASH_BITS-1 set), cells with attribute bit 7 set swap ink and paper.
- R7: Positions inside the margin of BORDER_H columns beside and BORDER_V lines around the bitmap show borderColour with vidBright at 0. borderColour is sampled one cycle before it is shown.
- R8: Outside the bitmap and border area, all colour outputs and vidBright are 0.
- R9: hSync is high for H_SYNC positions starting at h = 256 + BORDER_H + H_FRONT.
- R10: vSync is high for V_SYNC lines starting at v = 192 + BORDER_V + V_FRONT.
- R11: frameIrq pulses for one cycle, at h=0 of the first vSync line, so it coincides with the rising edge of vSync.
- R12: While rst is high, and for the 9 cycles after reset is released, every video output is 0 and memRd is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| memData | input | 8 | display memory byte for the address presented this cycle |
| borderColour | input | 3 | border colour, green/red/blue |
| memAddr | output | 14 | display memory byte address |
| memRd | output | 1 | video read in this cycle |
| vidGreen | output | 1 | green |
| vidRed | output | 1 | red |
| vidBlue | output | 1 | blue |
| vidBright | output | 1 | intensity |
| hSync | output | 1 | horizontal sync, active high |
| vSync | output | 1 | vertical sync, active high |
| frameIrq | output | 1 | one-cycle frame interrupt |

## Verification
Memory reads are due in the same cycle as their fetch position. Colour, sync and interrupt are due exactly 9 cycles later, and a border colour change shows one cycle after it is applied. The bench holds a cycle index n that starts at the release of reset. For each cycle it queues the expected read for position n and the expected video for position n-9. A monitor compares these on the falling edge, away from the edge where the design updates. Two full frames are covered with the flash phase toggling every frame and the border changing mid-line, so the flash swap, the intensity masking and the border latency are all checked.

// File: rtl/vidgen_pkg.sv
package vidgen_pkg;
  localparam int BMP_COLS = 256;
  localparam int BMP_ROWS = 192;
  localparam int PIPE_LAT = 9;

  typedef struct packed {
    logic bmpFetch;
    logic attrFetch;
    logic loadCell;
  } cell_strobe_t;

  typedef struct packed {
    logic bitmap;
    logic active;
    logic hsync;
    logic vsync;
    logic irq;
  } beam_flags_t;
endpackage

// File: rtl/vidgen_ctrl.sv
module vidgen_ctrl
  import vidgen_pkg::*;
#(
  parameter int BORDER_H = 32,
  parameter int H_FRONT = 16,
  parameter int H_SYNC = 32,
  parameter int H_BACK = 16,
  parameter int BORDER_V = 24,
  parameter int V_FRONT = 8,
  parameter int V_SYNC = 4,
  parameter int V_BACK = 12,
  parameter int FLASH_BITS = 5
) (
  input  logic         clk,
  input  logic         rst,
  output cell_strobe_t strobe,
  output beam_flags_t  flags,
  output logic         flashPhase,
  output logic [13:0]  memAddr,
  output logic         memRd
);
  localparam int H_TOTAL = BMP_COLS + 2 * BORDER_H + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = BMP_ROWS + 2 * BORDER_V + V_FRONT + V_SYNC + V_BACK;
  localparam int HS_START = BMP_COLS + BORDER_H + H_FRONT;
  localparam int VS_START = BMP_ROWS + BORDER_V + V_FRONT;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic [FLASH_BITS-1:0] frameCnt;
  logic lineEnd, frameEnd, inBitmap, hIn, vIn;
  logic [4:0] colByte;
  logic [7:0] row;

  assign lineEnd  = (hCnt == HW'(H_TOTAL - 1));
  assign frameEnd = lineEnd && (vCnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
      frameCnt <= '0;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + 1'b1;
      if (lineEnd) vCnt <= frameEnd ? '0 : vCnt + 1'b1;
      if (frameEnd) frameCnt <= frameCnt + 1'b1;
    end
  end

  assign flashPhase = frameCnt[FLASH_BITS-1];
  assign inBitmap = (hCnt < HW'(BMP_COLS)) && (vCnt < VW'(BMP_ROWS));
  assign colByte  = hCnt[7:3];
  assign row      = vCnt[7:0];

  always_comb begin
    strobe.bmpFetch  = !rst && inBitmap && (hCnt[2:0] == 3'd0);
    strobe.attrFetch = !rst && inBitmap && (hCnt[2:0] == 3'd2);
    strobe.loadCell  = inBitmap && (hCnt[2:0] == 3'd7);
  end

  assign memRd = strobe.bmpFetch || strobe.attrFetch;

  always_comb begin
    if (strobe.attrFetch) memAddr = 14'h1800 + 14'({row[7:3], colByte});
    else                  memAddr = {1'b0, row[7:6], row[2:0], row[5:3], colByte};
  end

  assign hIn = (hCnt < HW'(BMP_COLS + BORDER_H)) || (hCnt >= HW'(H_TOTAL - BORDER_H));
  assign vIn = (vCnt < VW'(BMP_ROWS + BORDER_V)) || (vCnt >= VW'(V_TOTAL - BORDER_V));

  always_comb begin
    flags.bitmap = inBitmap;
    flags.active = hIn && vIn;
    flags.hsync  = (hCnt >= HW'(HS_START)) && (hCnt < HW'(HS_START + H_SYNC));
    flags.vsync  = (vCnt >= VW'(VS_START)) && (vCnt < VW'(VS_START + V_SYNC));
    flags.irq    = (vCnt == VW'(VS_START)) && (hCnt == '0);
  end

  // R3: a video read never occupies two consecutive cycles
  p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (rst)
    memRd |=> !memRd);

  // R2: a bitmap read is followed, after one free cycle, by an attribute read
  p_attr_follows_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.bmpFetch |=> !memRd ##1 (memRd && memAddr[13:11] == 3'b011));
endmodule

// File: rtl/vidgen_datapath.sv
module vidgen_datapath
  import vidgen_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  cell_strobe_t strobe,
  input  beam_flags_t  flags,
  input  logic         flashPhase,
  input  logic [7:0]   memData,
  input  logic [2:0]   borderColour,
  output logic         vidGreen,
  output logic         vidRed,
  output logic         vidBlue,
  output logic         vidBright,
  output logic         hSync,
  output logic         vSync,
  output logic         frameIrq
);
  localparam int LAT = PIPE_LAT;

  logic [7:0] bmpHold, attrHold, shiftReg;
  logic [2:0] cellInk, cellPaper, pixColour, nextColour;
  logic cellBright, swapNow, nextBright;
  beam_flags_t flagPipe [LAT];
  beam_flags_t tap;

  assign swapNow = attrHold[7] && flashPhase;

  always_ff @(posedge clk) begin
    if (rst) begin
      bmpHold <= '0;
      attrHold <= '0;
      shiftReg <= '0;
      cellInk <= '0;
      cellPaper <= '0;
      cellBright <= 1'b0;
    end else begin
      if (strobe.bmpFetch) bmpHold <= memData;
      if (strobe.attrFetch) attrHold <= memData;
      if (strobe.loadCell) begin
        shiftReg <= bmpHold;
        cellInk <= swapNow ? attrHold[5:3] : attrHold[2:0];
        cellPaper <= swapNow ? attrHold[2:0] : attrHold[5:3];
        cellBright <= attrHold[6];
      end else begin
        shiftReg <= {shiftReg[6:0], 1'b0};
      end
    end
  end

  generate
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) flagPipe[s] <= '0;
        else if (s == 0) flagPipe[s] <= flags;
        else flagPipe[s] <= flagPipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign tap = flagPipe[LAT-2];
  assign pixColour = shiftReg[7] ? cellInk : cellPaper;

  always_comb begin
    if (tap.bitmap) begin
      nextColour = pixColour;
      nextBright = cellBright && (pixColour != 3'b000);
    end else if (tap.active) begin
      nextColour = borderColour;
      nextBright = 1'b0;
    end else begin
      nextColour = 3'b000;
      nextBright = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {vidGreen, vidRed, vidBlue} <= 3'b000;
      vidBright <= 1'b0;
    end else begin
      {vidGreen, vidRed, vidBlue} <= nextColour;
      vidBright <= nextBright;
    end
  end

  assign hSync = flagPipe[LAT-1].hsync;
  assign vSync = flagPipe[LAT-1].vsync;
  assign frameIrq = flagPipe[LAT-1].irq;

  // R8: sync only occurs inside blanking, where all colour is dark
  p_sync_dark_r8: assert property (@(posedge clk) disable iff (rst)
    (hSync || vSync) |-> ({vidGreen, vidRed, vidBlue} == 3'b000 && !vidBright));

  // R5: intensity never accompanies black
  p_black_dim_r5: assert property (@(posedge clk) disable iff (rst)
    vidBright |-> ({vidGreen, vidRed, vidBlue} != 3'b000));

  // R11: the interrupt marks the rising edge of vertical sync
  p_irq_edge_r11: assert property (@(posedge clk) disable iff (rst)
    frameIrq |-> (vSync && !$past(vSync)));

  // R11: the interrupt is a single-cycle pulse
  p_irq_single_r11: assert property (@(posedge clk) disable iff (rst)
    frameIrq |=> !frameIrq);
endmodule

// File: rtl/vidgen.sv
module vidgen
  import vidgen_pkg::*;
#(
  parameter int BORDER_H = 32,
  parameter int H_FRONT = 16,
  parameter int H_SYNC = 32,
  parameter int H_BACK = 16,
  parameter int BORDER_V = 24,
  parameter int V_FRONT = 8,
  parameter int V_SYNC = 4,
  parameter int V_BACK = 12,
  parameter int FLASH_BITS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  memData,
  input  logic [2:0]  borderColour,
  output logic [13:0] memAddr,
  output logic        memRd,
  output logic        vidGreen,
  output logic        vidRed,
  output logic        vidBlue,
  output logic        vidBright,
  output logic        hSync,
  output logic        vSync,
  output logic        frameIrq
);
  cell_strobe_t strobe;
  beam_flags_t flags;
  logic flashPhase;

  vidgen_ctrl #(
    .BORDER_H(BORDER_H), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .BORDER_V(BORDER_V), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .FLASH_BITS(FLASH_BITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .flags(flags),
    .flashPhase(flashPhase), .memAddr(memAddr), .memRd(memRd)
  );

  vidgen_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .flags(flags),
    .flashPhase(flashPhase), .memData(memData), .borderColour(borderColour),
    .vidGreen(vidGreen), .vidRed(vidRed), .vidBlue(vidBlue),
    .vidBright(vidBright), .hSync(hSync), .vSync(vSync), .frameIrq(frameIrq)
  );
endmodule

// File: tb/vidgen_test.sv
`timescale 1ns/1ps
module vidgen_test;
  localparam int BH = 4, HF = 2, HS = 4, HB = 2;
  localparam int BV = 2, VF = 1, VS = 2, VB = 1;
  localparam int FB = 1;
  localparam int HT = 256 + 2 * BH + HF + HS + HB;
  localparam int VT = 192 + 2 * BV + VF + VS + VB;
  localparam int FRAME = HT * VT;
  localparam int RUN = 2 * FRAME + 20;
  localparam int N_CHANGE = FRAME + 266;
  localparam logic [2:0] B0 = 3'b010, B1 = 3'b101;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] borderColour = B0;
  logic [7:0] memData;
  logic [13:0] memAddr;
  logic memRd, vidGreen, vidRed, vidBlue, vidBright, hSync, vSync, frameIrq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    int n; logic [2:0] col; logic bri, hs, vs, irq, rd; logic [13:0] addr;
    string colTag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  vidgen #(.BORDER_H(BH), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
           .BORDER_V(BV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
           .FLASH_BITS(FB)) uut (
    .clk(clk), .rst(rst), .memData(memData), .borderColour(borderColour),
    .memAddr(memAddr), .memRd(memRd), .vidGreen(vidGreen), .vidRed(vidRed),
    .vidBlue(vidBlue), .vidBright(vidBright), .hSync(hSync), .vSync(vSync),
    .frameIrq(frameIrq));

  function automatic logic [7:0] memFn(input logic [13:0] a);
    return a[7:0] ^ (8'(a[13:8]) * 8'd29) ^ 8'h3c;
  endfunction
  assign memData = memFn(memAddr);

  function automatic logic [13:0] bmpAddr(input int x, input int y);
    logic [7:0] yy; logic [4:0] xx;
    yy = 8'(y); xx = 5'(x);
    return {1'b0, yy[7:6], yy[2:0], yy[5:3], xx};
  endfunction

  function automatic logic [13:0] attrAddr(input int x, input int y);
    return 14'(6144 + (y / 8) * 32 + x);
  endfunction

  task automatic check(input string tag, input int n, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, n, act, expv);
    end
  endtask

  task automatic pushExpected(input int n);
    exp_t e;
    int p, h, v, f, hr, vr, x;
    logic [7:0] bmp, attr;
    logic [2:0] ink, paper, border;
    e.n = n;
    hr = n % HT; vr = (n / HT) % VT;
    e.rd = (hr < 256) && (vr < 192) && ((hr % 8) == 0 || (hr % 8) == 2);
    e.addr = (hr % 8 == 2) ? attrAddr(hr / 8, vr) : bmpAddr(hr / 8, vr);
    p = n - 9;
    e.col = 3'b000; e.bri = 1'b0; e.hs = 1'b0; e.vs = 1'b0; e.irq = 1'b0;
    e.colTag = "R12";
    if (p >= 0) begin
      h = p % HT; v = (p / HT) % VT; f = p / FRAME;
      border = (n - 1 >= N_CHANGE) ? B1 : B0;
      e.hs = (h >= 256 + BH + HF) && (h < 256 + BH + HF + HS);
      e.vs = (v >= 192 + BV + VF) && (v < 192 + BV + VF + VS);
      e.irq = (v == 192 + BV + VF) && (h == 0);
      if (h < 256 && v < 192) begin
        x = h / 8;
        bmp = memFn(bmpAddr(x, v));
        attr = memFn(attrAddr(x, v));
        ink = attr[2:0]; paper = attr[5:3];
        e.colTag = "R4";
        if (attr[7] && (((f >> (FB - 1)) & 1) == 1)) begin
          ink = attr[5:3]; paper = attr[2:0];
          e.colTag = "R6";
        end
        e.col = bmp[7 - (h % 8)] ? ink : paper;
        e.bri = attr[6] && (e.col != 3'b000);
      end else if ((h < 256 + BH || h >= HT - BH) && (v < 192 + BV || v >= VT - BV)) begin
        e.col = border;
        e.colTag = "R7";
      end else begin
        e.colTag = "R8";
      end
    end
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.colTag, e.n, {vidGreen, vidRed, vidBlue}, e.col);
      check("R5", e.n, vidBright, e.bri);
      check("R9", e.n, hSync, e.hs);
      check("R10", e.n, vSync, e.vs);
      check("R11", e.n, frameIrq, e.irq);
      check("R3", e.n, memRd, e.rd);
      if (e.rd) check((e.n % HT) % 8 == 2 ? "R2" : "R1", e.n, memAddr, e.addr);
    end
  end

  // driver
  initial begin
    repeat (5) @(posedge clk);
    #1;
    // R12: reset state
    check("R12", -1, {vidGreen, vidRed, vidBlue, vidBright}, 0);
    check("R12", -1, {hSync, vSync, frameIrq}, 0);
    check("R12", -1, memRd, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    for (int n = 0; n < RUN; n++) begin
      if (n == N_CHANGE) borderColour = B1;
      pushExpected(n);
      @(posedge clk); #1;
    end
    wait (q.size() == 0);
    @(posedge clk); #1;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    #(4 * 160000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R12 cycle=timeout actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule